// File: doc/BRIEF.md
# Dual-Loop Sign-Sign Equalizer Adapter

This block is the digital engine that tunes a serial link's transmit pre-emphasis and the receiver's reference level. It uses only one monitoring sampler. On each received symbol it takes three inputs: the recovered data bit, the sign of the monitor sampler's error against the current reference, and a valid strobe. From these it runs two coupled sign-sign loops. One loop moves the post-cursor tap weights. The other moves a 9-bit reference-level code that positions the monitor sampler. Both loops are driven by the same error sample.

Updates are data-filtered. A symbol counts only when the data pattern shows that the received level is the one where the monitor currently sits. Each loop collects the signs of a programmable number of accepted symbols before it takes one step. This lets the relative rates of the two loops be set independently. The main tap is never adapted on its own. It is always derived from a peak-swing budget minus the magnitudes of the post taps.

In partial-response (one-tap DFE) mode the block alternates between two lock phases. The upper phase locks the reference to the (1,1) level and the lower phase locks it to the (0,1) level. The first post tap is frozen during this mode. At the end of each phase the locked reference code is captured, so that downstream logic can compute the trailing-ISI magnitude from the two captured codes.

Top module: `ss_lms_adapter`

## Requirements
- R1: In reset, every post tap is 0, the reference code is LEV_INIT (256), the phase is upper (0), both captured codes are 0, and the main tap is 0. After reset is released, the main tap equals peak_lim within two clock edges.
- R2: Define sign(bit) as +1 for bit 1 and -1 for bit 0, and sign(err_hi) as +1 when err_hi is 1. On each accepted symbol, post tap k (tap k sits at bits [(k-1)*WW +: WW] of post_taps) receives the vote sign(d[n-k])*sign(err_hi). When the tap's accumulation completes, the tap moves by tap_step in the direction of the net vote.
- R3: On each accepted symbol, the reference code receives the vote -sign(err_hi). When its accumulation completes, it moves by lev_step in the direction of the net vote. It never changes by more than lev_step in one step.
- R4: With dfe_en low, a symbol is accepted only when d_bit is 1. Symbols with d_bit 0 leave the taps, the reference code and the vote state untouched.
- R5: A loop with a length setting L takes one step after max(L,1) accepted symbols. It moves up when the vote sum is positive, down when it is negative, and not at all when the sum is zero. Its vote sum then clears.
- R6: Post taps saturate at ±(2^(WW-1)-1). The reference code saturates at 0 and 2^LW-1.
- R7: main_tap equals max(0, peak_lim - sum of |post taps|), and follows a tap or peak_lim change one clock edge later.
- R8: With dfe_en high, a symbol is accepted only when d[n-1] is 1. In addition, d[n] must be 1 in the upper phase (lock_phase 0) and 0 in the lower phase (lock_phase 1).
- R9: With dfe_en high, post tap 1 holds its value. The other post taps keep adapting.
- R10: With dfe_en high, after max(phase_len,1) reference steps the block captures the reference code (into lock_upper in the upper phase, into lock_lower in the lower phase) and toggles the phase. With dfe_en low, the phase returns to upper and the step count clears.
- R11: Without sym_vld, no tap and no reference code changes, whatever d_bit and err_hi do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_vld | input | 1 | A symbol decision and error sign are present |
| d_bit | input | 1 | Current data decision d[n] |
| err_hi | input | 1 | Error sign from the monitor sampler, 1 = positive |
| dfe_en | input | 1 | Partial-response lock mode enable |
| tap_step | input | WW-1 | Tap step size |
| lev_step | input | LW-1 | Reference step size |
| tap_len | input | CW | Accepted symbols per tap step |
| lev_len | input | CW | Accepted symbols per reference step |
| phase_len | input | CW | Reference steps per lock phase |
| peak_lim | input | PW | Peak-swing budget for the sum of tap magnitudes |
| post_taps | output | NPOST*WW | Signed post-cursor taps, tap 1 in the low bits |
| main_tap | output | PW | Derived main tap |
| dlev | output | LW | Reference-level code for the monitor sampler |
| lock_phase | output | 1 | Current lock phase, 0 upper, 1 lower |
| lock_upper | output | LW | Reference code captured at the end of an upper phase |
| lock_lower | output | LW | Reference code captured at the end of a lower phase |

## Verification
The taps and the reference code change on the first rising edge that samples an accepted symbol. The main tap, the phase and the captured codes change on the following edge. The bench therefore drops sym_vld for one cycle after every symbol and samples on the falling edge after the second rising edge. By then every result from that symbol is due and none from a later symbol can interfere. The expected values come from an arithmetic model of the vote, saturation, budget and phase rules, stepped once per symbol. Loop lengths, steps, modes and the budget are swept, and saturation is forced with long runs of constant error.

// File: rtl/ss_lms_pkg.sv
package ss_lms_pkg;
  typedef enum logic {
    PH_UPPER = 1'b0,
    PH_LOWER = 1'b1
  } lock_ph_e;
endpackage

// File: rtl/ss_loop.sv
// One sign-sign loop: collects votes over len accepted events, then steps
// the value by step in the direction of the net vote, with saturation.
module ss_loop #(
  parameter int W     = 8,
  parameter int SW    = 7,
  parameter int CW    = 4,
  parameter bit SGN   = 1'b1,
  parameter int MINV  = -127,
  parameter int MAXV  = 127,
  parameter int INITV = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev,
  input  logic          up,
  input  logic          freeze,
  input  logic [CW-1:0] len,
  input  logic [SW-1:0] step,
  output logic [W-1:0]  val,
  output logic          done
);
  localparam int AW = CW + 2;
  localparam logic signed [AW-1:0] ONE = AW'(1);
  localparam logic signed [W+1:0]  HI  = (W+2)'(MAXV);
  localparam logic signed [W+1:0]  LO  = (W+2)'(MINV);

  logic [CW-1:0]         cnt;
  logic signed [AW-1:0]  acc, tot;
  logic                  last;
  logic signed [W+1:0]   wide, stepw, cand, nxt;

  always_comb begin
    tot   = up ? (acc + ONE) : (acc - ONE);
    last  = (len <= CW'(1)) || (cnt >= len - CW'(1));
    wide  = $signed({{2{SGN ? val[W-1] : 1'b0}}, val});
    stepw = $signed({{(W+2-SW){1'b0}}, step});
    if (tot > 0)      cand = wide + stepw;
    else if (tot < 0) cand = wide - stepw;
    else              cand = wide;
    if (cand > HI)      nxt = HI;
    else if (cand < LO) nxt = LO;
    else                nxt = cand;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val  <= W'(INITV);
      cnt  <= '0;
      acc  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ev) begin
        if (last) begin
          acc  <= '0;
          cnt  <= '0;
          done <= 1'b1;
          if (!freeze) val <= nxt[W-1:0];
        end else begin
          acc <= tot;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pat_filter.sv
// Data history and level filter: decides whether the current symbol
// sits at the level the monitor sampler is placed on.
module pat_filter
  import ss_lms_pkg::*;
#(
  parameter int NPOST = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sym_vld,
  input  logic           d_bit,
  input  logic           dfe_en,
  input  lock_ph_e       phase,
  output logic           accept,
  output logic [NPOST:1] hist
);
  always_comb begin
    if (dfe_en)
      accept = sym_vld && hist[1] && ((phase == PH_UPPER) ? d_bit : !d_bit);
    else
      accept = sym_vld && d_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (sym_vld) begin
      hist[1] <= d_bit;
      for (int k = 2; k <= NPOST; k++) hist[k] <= hist[k-1];
    end
  end
endmodule

// File: rtl/main_calc.sv
// Main tap from the peak-swing budget minus the post-tap magnitudes.
// Recomputed when a tap loop steps or the budget changes.
module main_calc #(
  parameter int NPOST = 2,
  parameter int WW    = 8,
  parameter int PW    = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPOST*WW-1:0] taps,
  input  logic [NPOST:1]      tap_done,
  input  logic [PW-1:0]       lim,
  output logic [PW-1:0]       main_tap
);
  logic [PW-1:0]        lim_q;
  logic [PW:0]          mag_sum;
  logic signed [PW+1:0] diff;
  logic signed [WW-1:0] t;
  logic [WW-1:0]        m;

  always_comb begin
    mag_sum = '0;
    t = '0;
    m = '0;
    for (int k = 0; k < NPOST; k++) begin
      t = $signed(taps[k*WW +: WW]);
      m = t[WW-1] ? WW'(-t) : WW'(t);
      mag_sum = mag_sum + (PW+1)'(m);
    end
    diff = $signed({2'b00, lim}) - $signed({1'b0, mag_sum});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      main_tap <= '0;
      lim_q    <= '0;
    end else begin
      lim_q <= lim;
      if ((|tap_done) || (lim != lim_q))
        main_tap <= (diff < 0) ? '0 : diff[PW-1:0];
    end
  end
endmodule

// File: rtl/ss_lms_adapter.sv
module ss_lms_adapter
  import ss_lms_pkg::*;
#(
  parameter int NPOST    = 2,
  parameter int WW       = 8,
  parameter int LW       = 9,
  parameter int CW       = 4,
  parameter int LEV_INIT = 256,
  localparam int PW      = WW + $clog2(NPOST + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sym_vld,
  input  logic                d_bit,
  input  logic                err_hi,
  input  logic                dfe_en,
  input  logic [WW-2:0]       tap_step,
  input  logic [LW-2:0]       lev_step,
  input  logic [CW-1:0]       tap_len,
  input  logic [CW-1:0]       lev_len,
  input  logic [CW-1:0]       phase_len,
  input  logic [PW-1:0]       peak_lim,
  output logic [NPOST*WW-1:0] post_taps,
  output logic [PW-1:0]       main_tap,
  output logic [LW-1:0]       dlev,
  output logic                lock_phase,
  output logic [LW-1:0]       lock_upper,
  output logic [LW-1:0]       lock_lower
);
  localparam int TMAX = 2**(WW-1) - 1;
  localparam int LMAX = 2**LW - 1;

  lock_ph_e       phase;
  logic           accept;
  logic [NPOST:1] hist;
  logic [NPOST:1] tap_done;
  logic           lev_done;
  logic [CW-1:0]  pcnt;
  logic           plast;

  pat_filter #(.NPOST(NPOST)) u_filt (
    .clk(clk), .rst(rst), .sym_vld(sym_vld), .d_bit(d_bit),
    .dfe_en(dfe_en), .phase(phase), .accept(accept), .hist(hist)
  );

  for (genvar k = 1; k <= NPOST; k++) begin : g_tap
    ss_loop #(
      .W(WW), .SW(WW-1), .CW(CW), .SGN(1'b1),
      .MINV(-TMAX), .MAXV(TMAX), .INITV(0)
    ) u_tap (
      .clk(clk), .rst(rst), .ev(accept),
      .up(~(hist[k] ^ err_hi)),
      .freeze(dfe_en && (k == 1)),
      .len(tap_len), .step(tap_step),
      .val(post_taps[(k-1)*WW +: WW]),
      .done(tap_done[k])
    );
  end

  ss_loop #(
    .W(LW), .SW(LW-1), .CW(CW), .SGN(1'b0),
    .MINV(0), .MAXV(LMAX), .INITV(LEV_INIT)
  ) u_lev (
    .clk(clk), .rst(rst), .ev(accept), .up(~err_hi), .freeze(1'b0),
    .len(lev_len), .step(lev_step), .val(dlev), .done(lev_done)
  );

  main_calc #(.NPOST(NPOST), .WW(WW), .PW(PW)) u_main (
    .clk(clk), .rst(rst), .taps(post_taps), .tap_done(tap_done),
    .lim(peak_lim), .main_tap(main_tap)
  );

  // Lock-phase sequencer: counts reference steps, captures and toggles.
  assign plast = (phase_len <= CW'(1)) || (pcnt >= phase_len - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_UPPER;
      pcnt       <= '0;
      lock_upper <= '0;
      lock_lower <= '0;
    end else if (!dfe_en) begin
      phase <= PH_UPPER;
      pcnt  <= '0;
    end else if (lev_done) begin
      if (plast) begin
        if (phase == PH_UPPER) lock_upper <= dlev;
        else                   lock_lower <= dlev;
        phase <= (phase == PH_UPPER) ? PH_LOWER : PH_UPPER;
        pcnt  <= '0;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  assign lock_phase = (phase == PH_LOWER);
endmodule

// File: rtl/ss_lms_adapter_chk.sv
module ss_lms_adapter_chk #(
  parameter int NPOST    = 2,
  parameter int WW       = 8,
  parameter int LW       = 9,
  parameter int CW       = 4,
  localparam int PW      = WW + $clog2(NPOST + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                sym_vld,
  input logic                d_bit,
  input logic                dfe_en,
  input logic [LW-2:0]       lev_step,
  input logic [PW-1:0]       peak_lim,
  input logic [NPOST*WW-1:0] post_taps,
  input logic [PW-1:0]       main_tap,
  input logic [LW-1:0]       dlev,
  input logic                lock_phase
);
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(sym_vld) |-> ($stable(dlev) && $stable(post_taps))); // R11

  AST_LEV_STEP: assert property (@(posedge clk) disable iff (rst)
    ((dlev >= $past(dlev)) ? (dlev - $past(dlev)) : ($past(dlev) - dlev))
      <= {1'b0, $past(lev_step)}); // R3

  AST_ZERO_SYMBOL: assert property (@(posedge clk) disable iff (rst)
    ($past(sym_vld) && !$past(d_bit) && !$past(dfe_en)) |-> $stable(dlev)); // R4

  AST_TAP1_FROZEN: assert property (@(posedge clk) disable iff (rst)
    $past(dfe_en) |-> $stable(post_taps[WW-1:0])); // R9

  AST_MAIN_BUDGET: assert property (@(posedge clk) disable iff (rst)
    main_tap <= $past(peak_lim)); // R7

  AST_PHASE_MODE: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_phase) |-> $past(dfe_en)); // R10
endmodule

bind ss_lms_adapter ss_lms_adapter_chk #(
  .NPOST(NPOST), .WW(WW), .LW(LW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .sym_vld(sym_vld), .d_bit(d_bit), .dfe_en(dfe_en),
  .lev_step(lev_step), .peak_lim(peak_lim), .post_taps(post_taps),
  .main_tap(main_tap), .dlev(dlev), .lock_phase(lock_phase)
);

// File: tb/ss_lms_adapter_test.sv
module ss_lms_adapter_test;
  localparam int NPOST = 2;
  localparam int WW    = 6;
  localparam int LW    = 9;
  localparam int CW    = 3;
  localparam int LINIT = 256;
  localparam int PW    = WW + $clog2(NPOST + 1);
  localparam int TMAX  = 2**(WW-1) - 1;
  localparam int LMAX  = 2**LW - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                rst = 1'b1;
  logic                sym_vld = 1'b0, d_bit = 1'b0, err_hi = 1'b0, dfe_en = 1'b0;
  logic [WW-2:0]       tap_step = 1;
  logic [LW-2:0]       lev_step = 2;
  logic [CW-1:0]       tap_len = 1, lev_len = 1, phase_len = 2;
  logic [PW-1:0]       peak_lim = 40;
  logic [NPOST*WW-1:0] post_taps;
  logic [PW-1:0]       main_tap;
  logic [LW-1:0]       dlev, lock_upper, lock_lower;
  logic                lock_phase;

  ss_lms_adapter #(.NPOST(NPOST), .WW(WW), .LW(LW), .CW(CW), .LEV_INIT(LINIT)) uut (
    .clk(clk), .rst(rst), .sym_vld(sym_vld), .d_bit(d_bit), .err_hi(err_hi),
    .dfe_en(dfe_en), .tap_step(tap_step), .lev_step(lev_step),
    .tap_len(tap_len), .lev_len(lev_len), .phase_len(phase_len),
    .peak_lim(peak_lim), .post_taps(post_taps), .main_tap(main_tap),
    .dlev(dlev), .lock_phase(lock_phase), .lock_upper(lock_upper),
    .lock_lower(lock_lower)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] rs = 32'h1234_5678;

  // model state
  int mw [1:NPOST];
  int mwc[1:NPOST];
  int mwa[1:NPOST];
  int mh [1:NPOST];
  int mlv = LINIT, mlc = 0, mla = 0, mph = 0, mpc = 0, mlu = 0, mll = 0;

  function automatic int rnd_bit();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return int'(rs[7]);
  endfunction

  function automatic int sat(int v, int lo, int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic int sgn(int v);
    return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
  endfunction

  function automatic int absv(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int exp_main();
    int s = int'(peak_lim);
    for (int k = 1; k <= NPOST; k++) s = s - absv(mw[k]);
    return (s < 0) ? 0 : s;
  endfunction

  function automatic int tap_act(int k);
    logic signed [WW-1:0] t;
    t = $signed(post_taps[(k-1)*WW +: WW]);
    return int'(t);
  endfunction

  task automatic model_sym(input int d, input int e);
    int acc, v, eff, tot;
    bit ldone;
    ldone = 0;
    if (dfe_en) acc = (mh[1] == 1) && ((mph == 0) ? (d == 1) : (d == 0));
    else        acc = (d == 1);
    if (acc != 0) begin
      eff = (tap_len == 0) ? 1 : int'(tap_len);
      for (int k = 1; k <= NPOST; k++) begin
        v = (mh[k] == e) ? 1 : -1;
        if (mwc[k] + 1 >= eff) begin
          tot = mwa[k] + v;
          if (!(dfe_en && k == 1))
            mw[k] = sat(mw[k] + sgn(tot) * int'(tap_step), -TMAX, TMAX);
          mwa[k] = 0;
          mwc[k] = 0;
        end else begin
          mwa[k] = mwa[k] + v;
          mwc[k] = mwc[k] + 1;
        end
      end
      eff = (lev_len == 0) ? 1 : int'(lev_len);
      v = (e == 1) ? -1 : 1;
      if (mlc + 1 >= eff) begin
        tot = mla + v;
        mlv = sat(mlv + sgn(tot) * int'(lev_step), 0, LMAX);
        mla = 0;
        mlc = 0;
        ldone = 1;
      end else begin
        mla = mla + v;
        mlc = mlc + 1;
      end
    end
    if (ldone && dfe_en) begin
      eff = (phase_len == 0) ? 1 : int'(phase_len);
      if (mpc + 1 >= eff) begin
        if (mph == 0) mlu = mlv; else mll = mlv;
        mph = 1 - mph;
        mpc = 0;
      end else begin
        mpc = mpc + 1;
      end
    end
    for (int k = NPOST; k >= 2; k--) mh[k] = mh[k-1];
    mh[1] = d;
  endtask

  task automatic chk_all(input string tag);
    bit bad;
    n_chk++;
    bad = (tap_act(1) != mw[1]) || (tap_act(2) != mw[2]) ||
          (int'(dlev) != mlv) || (int'(main_tap) != exp_main()) ||
          (int'(lock_phase) != mph) || (int'(lock_upper) != mlu) ||
          (int'(lock_lower) != mll);
    if (bad) begin
      n_bad++;
      $display("FAIL %s: act taps %0d,%0d lev %0d main %0d ph %0d lk %0d/%0d exp taps %0d,%0d lev %0d main %0d ph %0d lk %0d/%0d",
        tag, tap_act(1), tap_act(2), dlev, main_tap, lock_phase, lock_upper, lock_lower,
        mw[1], mw[2], mlv, exp_main(), mph, mlu, mll);
    end
  endtask

  // one symbol then one idle cycle; sample two rising edges later
  task automatic send(input int d, input int e, input string tag);
    @(negedge clk);
    sym_vld = 1'b1;
    d_bit   = d[0];
    err_hi  = e[0];
    @(negedge clk);
    sym_vld = 1'b0;
    @(negedge clk);
    model_sym(d, e);
    chk_all(tag);
  endtask

  task automatic run_rand(input int n, input string tag);
    for (int i = 0; i < n; i++) send(rnd_bit(), rnd_bit(), tag);
  endtask

  task automatic set_dfe(input bit v);
    @(negedge clk);
    dfe_en = v;
    @(negedge clk);
    @(negedge clk);
    if (!v) begin
      mph = 0;
      mpc = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: act running exp finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 1; k <= NPOST; k++) begin
      mw[k] = 0; mwc[k] = 0; mwa[k] = 0; mh[k] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk_all("R1");

    run_rand(150, "R2");

    tap_step = 2; lev_step = 5;
    run_rand(150, "R3");

    for (int i = 0; i < 30; i++) send(0, rnd_bit(), "R4");

    tap_len = 3; lev_len = 5;
    run_rand(200, "R5");
    tap_len = 0; lev_len = 0;
    run_rand(60, "R5");
    tap_len = 2; lev_len = 7;
    run_rand(120, "R5");

    tap_len = 1; lev_len = 1; tap_step = 20; lev_step = 200;
    for (int i = 0; i < 30; i++) send(1, 1, "R6");
    for (int i = 0; i < 30; i++) send(1, 0, "R6");
    for (int i = 0; i < 20; i++) send(i % 2, 0, "R6");

    tap_step = 3; lev_step = 4;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      peak_lim = (j == 0) ? 0 : ((j == 1) ? 17 : ((j == 2) ? 63 : 255));
      @(negedge clk);
      @(negedge clk);
      chk_all("R7");
      run_rand(40, "R7");
    end

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      d_bit = rnd_bit();
      err_hi = rnd_bit();
    end
    @(negedge clk);
    chk_all("R11");

    tap_step = 1; lev_step = 3; phase_len = 3;
    set_dfe(1'b1);
    run_rand(300, "R8");
    tap_len = 2; lev_len = 1;
    run_rand(100, "R9");
    phase_len = 0;
    run_rand(100, "R10");
    set_dfe(1'b0);
    chk_all("R10");
    run_rand(40, "R10");
    set_dfe(1'b1);
    phase_len = 4;
    run_rand(150, "R10");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule